// File: doc/BRIEF.md
# Configurable Edge Interrupt Event Detector

This block watches a group of live status bits for each of several line channels and turns changes of those bits into latched interrupt events. Each channel has eight status sources. For every source, a per-channel trigger-mode register chooses whether only a low-to-high change counts, or whether a change in either direction counts. Each detected event sets a sticky flag. The flag stays set until the host writes a 1 to its bit. A per-channel enable register decides which flags drive the single combined, active-high interrupt output.

The host reaches the registers over a simple byte-wide bus: an address, write data and a write strobe. A read returns the addressed register on the data output one clock after the address is presented. Channel n occupies a 0x20-byte window starting at 0x20·n. Inside that window, the trigger-mode register sits at offset 0x13, the flag register at 0x14 and the enable register at 0x15.

Top module: `edge_irq_hub`

## Requirements
- R1: The trigger-mode register of channel n is at address 0x13 + 0x20·n. It resets to 0, and it reads back the last value written. Read data for any address appears on `rdata_o` one clock after that address is on `addr_i`.
- R2: While a mode bit is 0, a 0-to-1 change of the matching status bit sets the matching flag bit. A 1-to-0 change does not set it.
- R3: While a mode bit is 1, both a 0-to-1 and a 1-to-0 change of the matching status bit set the matching flag bit.
- R4: Leaving reset never creates an event. A status bit that is already 1 when reset ends leaves its flag (offset 0x14) at 0.
- R5: A flag bit, once set, stays set until a write of 1 to that bit of the flag register. Flag bits written with 0 are unchanged.
- R6: When an event and a write-1 clear of the same flag bit occur in the same clock, the flag ends up set.
- R7: The enable register (offset 0x15) resets to 0. `irq_o` is 1 exactly when some flag bit, in any channel, is set together with its enable bit. With all enables at 0, `irq_o` is 0.
- R8: Changing a mode bit leaves flags that are already set as they are. The new mode governs only status changes after the write.
- R9: Writes to addresses that hold none of the three registers change no register. Reads of such addresses return 0.
- R10: Bit i of a channel's mode, flag and enable registers belongs to status input `status_i[8·n + i]`. Bits 7 down to 0 carry, in order: equalizer out of range, loopback-activate code seen, loopback-deactivate code seen, test-pattern sync, transmit clock lost, driver fault, alarm indication and signal lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_i | input | 64 | Live status bits, channel n in bits 8n+7..8n |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per clock while high |
| rdata_o | output | 8 | Registered read data for the previous clock's address |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The hardest case to reach from the ports is an event and a write-1 clear hitting the same flag bit on the same clock edge. To force it, the bench changes the status bit and asserts the clearing write at the same falling edge, so both act on the next rising edge. A second awkward case is a status bit that is already high when reset ends. The bench holds one channel's status at all ones through reset, so the first-sample rule is the only thing that keeps its flags clear. The falling-edge checks start by clearing the flag a rise has set. Any flag seen after the fall therefore comes from the fall alone.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_MODE = 2'd1,
    RK_FLAG = 2'd2,
    RK_MASK = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] mode_i,
  output logic [W-1:0] evt_o
);

  logic [W-1:0] prev_q;
  logic         armed_q;

  // Rising changes always count; falling changes only where mode is 1.
  function automatic logic [W-1:0] edge_hits(input logic [W-1:0] prev,
                                             input logic [W-1:0] cur,
                                             input logic [W-1:0] both);
    edge_hits = (~prev & cur) | (both & prev & ~cur);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= cur_i;
      armed_q <= 1'b1;
    end
  end

  assign evt_o = armed_q ? edge_hits(prev_q, cur_i, mode_i) : '0;

  // R2
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & ~mode_i & prev_q & ~cur_i) == '0));

endmodule

// File: rtl/edge_irq_chan.sv
module edge_irq_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic         mode_we_i,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mode_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] evt_o,
  output logic         pend_o
);

  logic [W-1:0] mode_q, mask_q, flags_q, clr_mask, evt;

  edge_irq_detect #(.W(W)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_i  (status_i),
    .mode_i (mode_q),
    .evt_o  (evt)
  );

  // Write-1 clear; a same-cycle event overrides it.
  function automatic logic [W-1:0] next_flags(input logic [W-1:0] cur,
                                              input logic [W-1:0] clr,
                                              input logic [W-1:0] hit);
    next_flags = (cur & ~clr) | hit;
  endfunction

  assign clr_mask = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      if (mode_we_i) mode_q <= wdata_i;
      if (mask_we_i) mask_q <= wdata_i;
      flags_q <= next_flags(flags_q, clr_mask, evt);
    end
  end

  assign mode_o  = mode_q;
  assign mask_o  = mask_q;
  assign flags_o = flags_q;
  assign evt_o   = evt;
  assign pend_o  = |(flags_q & mask_q);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flags_q) & ~$past(clr_mask) & ~flags_q) == '0));

  // R6
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt) & ~flags_q) == '0));

endmodule

// File: rtl/edge_irq_rdmux.sv
module edge_irq_rdmux
  import edge_irq_pkg::*;
#(
  parameter int W      = 8,
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit_i,
  input  reg_kind_e           kind_i,
  input  logic [CH_W-1:0]     ch_i,
  input  logic [NUM_CH*W-1:0] mode_all_i,
  input  logic [NUM_CH*W-1:0] flag_all_i,
  input  logic [NUM_CH*W-1:0] mask_all_i,
  output logic [W-1:0]        rdata_o
);

  logic [W-1:0] sel_d, rdata_q;

  always_comb begin
    sel_d = '0;
    if (hit_i) begin
      unique case (kind_i)
        RK_MODE: sel_d = mode_all_i[ch_i*W +: W];
        RK_FLAG: sel_d = flag_all_i[ch_i*W +: W];
        RK_MASK: sel_d = mask_all_i[ch_i*W +: W];
        default: sel_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= sel_d;
  end

  assign rdata_o = rdata_q;

  // R9
  unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i || kind_i == RK_NONE) |=> (rdata_o == '0));

endmodule

// File: rtl/edge_irq_hub.sv
module edge_irq_hub
  import edge_irq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_SRC   = 8,
  parameter int ADDR_W    = 8,
  parameter int CH_STRIDE = 32,
  parameter int MODE_OFS  = 'h13,
  parameter int FLAG_OFS  = 'h14,
  parameter int MASK_OFS  = 'h15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH*NUM_SRC-1:0] status_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NUM_SRC-1:0]        wdata_i,
  input  logic                      we_i,
  output logic [NUM_SRC-1:0]        rdata_o,
  output logic                      irq_o
);

  localparam int OFS_W = $clog2(CH_STRIDE);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int TOT_W = NUM_CH * NUM_SRC;

  logic [CH_W-1:0]  dec_ch;
  logic [OFS_W-1:0] dec_ofs;
  logic             dec_hit;
  reg_kind_e        dec_kind;

  logic [TOT_W-1:0]  mode_all, flag_all, mask_all, evt_all;
  logic [NUM_CH-1:0] pend;
  logic              evt_any;

  function automatic reg_kind_e kind_of(input logic [OFS_W-1:0] ofs);
    if (32'(ofs) == MODE_OFS)      kind_of = RK_MODE;
    else if (32'(ofs) == FLAG_OFS) kind_of = RK_FLAG;
    else if (32'(ofs) == MASK_OFS) kind_of = RK_MASK;
    else                           kind_of = RK_NONE;
  endfunction

  always_comb begin
    dec_ofs  = addr_i[OFS_W-1:0];
    dec_ch   = addr_i[OFS_W +: CH_W];
    dec_hit  = ((addr_i >> (OFS_W + CH_W)) == '0) && (32'(dec_ch) < NUM_CH);
    dec_kind = kind_of(dec_ofs);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_sel;
    assign ch_sel = we_i && dec_hit && (dec_ch == CH_W'(c));

    edge_irq_chan #(.W(NUM_SRC)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .status_i  (status_i[c*NUM_SRC +: NUM_SRC]),
      .mode_we_i (ch_sel && dec_kind == RK_MODE),
      .mask_we_i (ch_sel && dec_kind == RK_MASK),
      .clr_we_i  (ch_sel && dec_kind == RK_FLAG),
      .wdata_i   (wdata_i),
      .mode_o    (mode_all[c*NUM_SRC +: NUM_SRC]),
      .mask_o    (mask_all[c*NUM_SRC +: NUM_SRC]),
      .flags_o   (flag_all[c*NUM_SRC +: NUM_SRC]),
      .evt_o     (evt_all[c*NUM_SRC +: NUM_SRC]),
      .pend_o    (pend[c])
    );
  end

  edge_irq_rdmux #(.W(NUM_SRC), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (dec_hit),
    .kind_i     (dec_kind),
    .ch_i       (dec_ch),
    .mode_all_i (mode_all),
    .flag_all_i (flag_all),
    .mask_all_i (mask_all),
    .rdata_o    (rdata_o)
  );

  assign evt_any = |evt_all;
  assign irq_o   = |pend;

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(evt_any) || $past(we_i)));

endmodule

// File: tb/edge_irq_hub_test.sv
module edge_irq_hub_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] st = 64'hFF << 24;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct {
    int       due;
    logic [7:0] exp;
    string    tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edge_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .status_i(st), .addr_i(addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // Monitor: compares each read result in the cycle it is due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      tests++;
      if (rdata_o !== it.exp) begin
        fails++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata_o, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr_i = a;
    it.due = cyc + 1; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic set_st(input logic [63:0] v);
    @(negedge clk);
    st = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    tests++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s: irq=%b expected=%b", tag, irq_o, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(8'h13, 8'h00, "R1 mode reset");
    rd(8'h15, 8'h00, "R7 enable reset");
    rd(8'h74, 8'h00, "R4 no event out of reset");
    chk_irq(1'b0, "R7 irq reset");
    // rise-only mode
    set_st(st | 64'h1);
    rd(8'h14, 8'h01, "R2 rise sets flag");
    wr(8'h14, 8'h01);
    rd(8'h14, 8'h00, "R5 write-1 clears");
    set_st(st & ~64'h1);
    rd(8'h14, 8'h00, "R2 fall ignored");
    // both-edge mode
    wr(8'h13, 8'h01);
    rd(8'h13, 8'h01, "R1 mode readback");
    set_st(st | 64'h1);
    wr(8'h14, 8'h01);
    set_st(st & ~64'h1);
    rd(8'h14, 8'h01, "R3 fall counts");
    wr(8'h14, 8'h01);
    // partial clear
    set_st(st | (64'hF << 8));
    rd(8'h34, 8'h0F, "R10 ch1 bits 3..0");
    wr(8'h34, 8'h05);
    rd(8'h34, 8'h0A, "R5 zero bits kept");
    // event wins over clear
    @(negedge clk);
    st = st | (64'h10 << 8);
    addr_i = 8'h34; wdata_i = 8'h10; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
    rd(8'h34, 8'h1A, "R6 event beats clear");
    // enables and irq
    chk_irq(1'b0, "R7 masked");
    wr(8'h35, 8'h02);
    chk_irq(1'b1, "R7 enabled flag");
    wr(8'h35, 8'h01);
    chk_irq(1'b0, "R7 enabled clear flag");
    wr(8'h35, 8'h00);
    // mode change keeps flags
    set_st(st | (64'h80 << 16));
    rd(8'h54, 8'h80, "R8 flag before mode change");
    wr(8'h53, 8'h80);
    rd(8'h54, 8'h80, "R8 flag kept over mode change");
    wr(8'h54, 8'h80);
    set_st(st & ~(64'h80 << 16));
    rd(8'h54, 8'h80, "R8 new mode on later fall");
    // last channel and cross-channel irq
    wr(8'hF3, 8'hA5);
    rd(8'hF3, 8'hA5, "R1 channel 7 mode");
    set_st(st | (64'h40 << 56));
    wr(8'hF5, 8'h40);
    chk_irq(1'b1, "R7 channel 7 irq");
    // unused addresses
    wr(8'h16, 8'hFF);
    wr(8'h00, 8'hFF);
    wr(8'h12, 8'hFF);
    rd(8'h16, 8'h00, "R9 unused read zero");
    rd(8'h13, 8'h01, "R9 mode untouched");
    rd(8'h14, 8'h00, "R9 flags untouched");
    rd(8'h15, 8'h00, "R9 enable untouched");
    // mapping
    set_st(st | (64'h04 << 40));
    rd(8'hB4, 8'h04, "R10 ch5 bit2");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule